// File: doc/BRIEF.md
# Host Bus DMA Handshake Bridge

This block connects an on-chip word FIFO to a 16-bit asynchronous host bus. The host reads and writes two small configuration registers with an active-low chip select, a read/write line, a register select line and two active-low byte strobes. Bulk data moves through a request/acknowledge handshake with an external DMA controller: the block lowers its request line when it can serve a burst, and the controller answers with one low-going acknowledge pulse per word.

A direction bit picks the flow. In read direction an internal producer fills the FIFO through a valid/ready stream and the host drains it by DMA. In write direction the host fills the FIFO by DMA and an internal consumer drains it through a valid/ready stream. Every host control input passes through a two-flop synchronizer before any edge is acted on. The pad driver is not modelled: the block drives a data word and an output enable. Back-pressure on both streams comes from FIFO occupancy only. A word moves on the clock edge where valid and ready are both high. The producer may hold valid high while ready is low. A stream that the current direction does not use has its ready or valid held low.

Top module: `hdma_bridge`

## Requirements
- R1: After reset the request output is high, the bus output enable is low, both stream handshake outputs are low, and both registers read back as zero.
- R2: While chip select is high, the block never drives the bus and byte strobe activity changes no register.
- R3: A selected write cycle (read/write line low) updates a register on the rising edge of a byte strobe. The low strobe writes bits 7:0 and the high strobe writes bits 15:8. Select 0 is the mode register, whose bit 0 is the direction (1 = FIFO to host). Select 1 is the control register, whose bit 15 is the transfer enable and whose bits 3:0 hold the burst level. All other bits read as zero.
- R4: A selected read cycle (read/write line high, at least one strobe low) drives the addressed register onto the bus with the output enable high.
- R5: While the acknowledge input is low, register reads and writes are ignored.
- R6: The request output stays high whenever the transfer enable bit is zero.
- R7: With enable set and no burst in progress, the request goes low when the available amount reaches the burst level. The available amount is FIFO occupancy in read direction and free space in write direction. A level of 0 acts as 1, and a level above the FIFO depth never raises a request.
- R8: A burst ends after as many completed acknowledge pulses as the burst level, and the request goes high for at least one cycle. The threshold is then checked again.
- R9: In read direction an accepted acknowledge drives the FIFO head word from its falling edge until its rising edge, and then pops exactly one word. Words leave in FIFO order.
- R10: In write direction the bus word present before the acknowledge rising edge is pushed once into the FIFO at that edge.
- R11: An acknowledge pulse that begins while the request is high is ignored: no drive, no push, no pop.
- R12: The input stream is ready only in read direction with the FIFO not full. The output stream is valid only in write direction with the FIFO not empty. Its data is the FIFO head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_cs_n_i | input | 1 | Chip select, active low |
| host_rw_i | input | 1 | 1 = register read, 0 = register write |
| host_sel_i | input | 1 | Register select: 0 mode, 1 control |
| host_uds_n_i | input | 1 | High byte strobe, active low |
| host_lds_n_i | input | 1 | Low byte strobe, active low |
| host_d_i | input | 16 | Data from the host bus |
| host_d_o | output | 16 | Data toward the host bus |
| host_d_oe_o | output | 1 | Bus drive enable |
| dma_ack_n_i | input | 1 | DMA acknowledge, active low |
| dma_req_n_o | output | 1 | DMA request, active low |
| in_valid_i | input | 1 | Input stream valid |
| in_ready_o | output | 1 | Input stream ready |
| in_data_i | input | 16 | Input stream word |
| out_valid_o | output | 1 | Output stream valid |
| out_ready_i | input | 1 | Output stream ready |
| out_data_o | output | 16 | Output stream word |

## Verification
On every cycle the assertions check the following:
- the request clears within one cycle of the enable dropping;
- an acknowledge is taken only while the request is low;
- the request releases right after the last word of a burst;
- the FIFO is never pushed when full or popped when empty;
- the bus stays undriven while the block is deselected and idle.

Only the bench scenarios can show the other properties: byte-lane masking, the blocking of register access during an acknowledge, the word order through both directions, the threshold corners (level 0 and levels above depth), and that an acknowledge outside a request leaves the FIFO contents untouched.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic {REQ_IDLE, REQ_BURST} req_state_e;

  typedef struct packed {
    logic sel;
    logic rw;
    logic ack_n;
    logic uds_n;
    logic lds_n;
    logic cs_n;
  } host_ctl_t;

  localparam int unsigned CTL_W = $bits(host_ctl_t);
  localparam logic [CTL_W-1:0] CTL_IDLE = 6'b001111;
endpackage

// File: rtl/hdma_sync.sv
module hdma_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/hdma_fifo.sv
module hdma_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  a_r10_push_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r9_pop_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/hdma_regs.sv
module hdma_regs #(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          sel_i,
  input  logic          dir_bit_i,
  input  logic [LW-1:0] lvl_bits_i,
  input  logic          en_bit_i,
  output logic          dir_rd_o,
  output logic          en_o,
  output logic [LW-1:0] lvl_o,
  output logic [DW-1:0] rdata_o
);
  logic          dir_q, en_q;
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (wr_lo_i && !sel_i) dir_q <= dir_bit_i;
      if (wr_lo_i &&  sel_i) lvl_q <= lvl_bits_i;
      if (wr_hi_i &&  sel_i) en_q  <= en_bit_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o[DW-1]   = en_q;
      rdata_o[LW-1:0] = lvl_q;
    end else begin
      rdata_o[0] = dir_q;
    end
  end

  assign dir_rd_o = dir_q;
  assign en_o     = en_q;
  assign lvl_o    = lvl_q;
endmodule

// File: rtl/hdma_dreq.sv
module hdma_dreq
  import hdma_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dir_rd_i,
  input  logic [CW-1:0] lvl_i,
  input  logic [CW-1:0] count_i,
  input  logic          ack_fall_i,
  input  logic          ack_rise_i,
  output logic          req_n_o,
  output logic          active_o,
  output logic          done_o
);
  req_state_e    state_q;
  logic [CW-1:0] remain_q, lvl_eff, avail;
  logic          active_q, start;

  assign lvl_eff = (lvl_i == '0) ? CW'(1) : lvl_i;
  assign avail   = dir_rd_i ? count_i : (CW'(DEPTH) - count_i);
  assign done_o  = ack_rise_i && active_q;
  assign start   = en_i && (avail >= lvl_eff) && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= REQ_IDLE;
      remain_q <= '0;
      active_q <= 1'b0;
    end else begin
      if (ack_fall_i && state_q == REQ_BURST) active_q <= 1'b1;
      else if (ack_rise_i)                    active_q <= 1'b0;
      case (state_q)
        REQ_IDLE: begin
          if (start) begin
            state_q  <= REQ_BURST;
            remain_q <= lvl_eff;
          end
        end
        default: begin
          if (!en_i) begin
            state_q <= REQ_IDLE;
          end else if (done_o) begin
            if (remain_q == CW'(1)) state_q <= REQ_IDLE;
            remain_q <= remain_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign req_n_o  = (state_q != REQ_BURST);
  assign active_o = active_q;

  a_r6_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> req_n_o);
  a_r11_ack_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(!req_n_o));
  a_r8_release_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && remain_q == CW'(1) && state_q == REQ_BURST) |=> req_n_o);
endmodule

// File: rtl/hdma_bridge.sv
module hdma_bridge
  import hdma_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned DSTG = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_cs_n_i,
  input  logic          host_rw_i,
  input  logic          host_sel_i,
  input  logic          host_uds_n_i,
  input  logic          host_lds_n_i,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe_o,
  input  logic          dma_ack_n_i,
  output logic          dma_req_n_o,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  host_ctl_t        ctl_raw, ctl_s;
  logic [CTL_W-1:0] ctl_sync;
  logic [2:0]       strb_s, strb_prev_q, strb_rise;
  logic [DW-1:0]    dpipe_q [DSTG];
  logic [DW-1:0]    cap_data, reg_rdata, fifo_rdata, fifo_wdata;
  logic             reg_ok, wr_lo, wr_hi, reg_rd, dma_drive;
  logic             ack_fall, dir_rd, en;
  logic [CW-1:0]    lvl, fifo_cnt;
  logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic             dma_active, dma_done;

  assign ctl_raw = '{sel: host_sel_i, rw: host_rw_i, ack_n: dma_ack_n_i,
                     uds_n: host_uds_n_i, lds_n: host_lds_n_i, cs_n: host_cs_n_i};

  hdma_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ctl_raw),
    .sync_o  (ctl_sync)
  );
  assign ctl_s = host_ctl_t'(ctl_sync);

  assign strb_s = {ctl_s.ack_n, ctl_s.uds_n, ctl_s.lds_n};
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_prev_q <= 3'b111;
    else         strb_prev_q <= strb_s;
  end
  assign strb_rise = strb_s & ~strb_prev_q;
  assign ack_fall  = !strb_s[2] && strb_prev_q[2];

  for (genvar g = 0; g < DSTG; g++) begin : g_dpipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dpipe_q[g] <= '0;
      else if (g == 0) dpipe_q[g] <= host_d_i;
      else             dpipe_q[g] <= dpipe_q[(g == 0) ? 0 : g-1];
    end
  end
  assign cap_data = dpipe_q[DSTG-1];

  assign reg_ok = !ctl_s.cs_n && ctl_s.ack_n;
  assign wr_lo  = reg_ok && !ctl_s.rw && strb_rise[0];
  assign wr_hi  = reg_ok && !ctl_s.rw && strb_rise[1];
  assign reg_rd = reg_ok && ctl_s.rw && !(ctl_s.uds_n && ctl_s.lds_n);

  hdma_regs #(.DW(DW), .LW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .sel_i      (ctl_s.sel),
    .dir_bit_i  (cap_data[0]),
    .lvl_bits_i (cap_data[CW-1:0]),
    .en_bit_i   (cap_data[DW-1]),
    .dir_rd_o   (dir_rd),
    .en_o       (en),
    .lvl_o      (lvl),
    .rdata_o    (reg_rdata)
  );

  hdma_dreq #(.DEPTH(DEPTH)) u_dreq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .dir_rd_i   (dir_rd),
    .lvl_i      (lvl),
    .count_i    (fifo_cnt),
    .ack_fall_i (ack_fall),
    .ack_rise_i (strb_rise[2]),
    .req_n_o    (dma_req_n_o),
    .active_o   (dma_active),
    .done_o     (dma_done)
  );

  assign in_ready_o  = dir_rd && !fifo_full;
  assign out_valid_o = !dir_rd && !fifo_empty;
  assign fifo_push   = dir_rd ? (in_valid_i && in_ready_o) : dma_done;
  assign fifo_wdata  = dir_rd ? in_data_i : cap_data;
  assign fifo_pop    = dir_rd ? dma_done : (out_valid_o && out_ready_i);

  hdma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .count_o (fifo_cnt)
  );

  assign dma_drive   = dma_active && dir_rd;
  assign host_d_oe_o = reg_rd || dma_drive;
  assign host_d_o    = dma_drive ? fifo_rdata : reg_rdata;
  assign out_data_o  = fifo_rdata;

  a_r2_bus_idle_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_s.cs_n && !dma_active) |-> !host_d_oe_o);
endmodule

// File: tb/hdma_bridge_tb_top.sv
module hdma_bridge_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, rw, sel, uds_n, lds_n, ack_n;
  logic [DW-1:0] d_in, d_out, in_data, out_data;
  logic d_oe, req_n, in_valid, in_ready, out_valid, out_ready;

  hdma_bridge #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_n_i(cs_n), .host_rw_i(rw),
    .host_sel_i(sel), .host_uds_n_i(uds_n), .host_lds_n_i(lds_n),
    .host_d_i(d_in), .host_d_o(d_out), .host_d_oe_o(d_oe),
    .dma_ack_n_i(ack_n), .dma_req_n_o(req_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int checks = 0;
  int errors = 0;
  int rel_cnt = 0;
  logic prev_req = 1'b1;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_cycle(input logic cs_v, input logic s, input logic r,
                            input logic [DW-1:0] d, input logic [1:0] lanes,
                            output logic [DW-1:0] rd, output logic oe);
    @(negedge clk);
    cs_n = cs_v; sel = s; rw = r; d_in = d;
    cyc(2);
    lds_n = !lanes[0]; uds_n = !lanes[1];
    cyc(4);
    rd = d_out; oe = d_oe;
    lds_n = 1'b1; uds_n = 1'b1;
    cyc(3);
    cs_n = 1'b1; rw = 1'b0;
    cyc(3);
  endtask

  task automatic reg_write(input logic s, input logic [DW-1:0] d, input logic [1:0] lanes);
    logic [DW-1:0] rd; logic oe;
    host_cycle(1'b0, s, 1'b0, d, lanes, rd, oe);
  endtask

  task automatic reg_read_chk(input string req, input logic s, input logic [DW-1:0] exp);
    logic [DW-1:0] rd; logic oe;
    host_cycle(1'b0, s, 1'b1, '0, 2'b11, rd, oe);
    chk({req, " R4 read enable"}, oe, 1'b1);
    chk(req, rd, exp);
  endtask

  task automatic push_item(input logic [DW-1:0] d);
    @(negedge clk);
    chk("R12 in_ready", in_ready, 1'b1);
    in_valid = 1'b1; in_data = d;
    exp_q.push_back(d);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    while (req_n !== 1'b0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk({req, " request seen"}, req_n, 1'b0);
  endtask

  task automatic dma_read(input string req);
    logic [DW-1:0] e;
    wait_req(req);
    ack_n = 1'b0;
    cyc(4);
    chk({req, " R9 drive on"}, d_oe, 1'b1);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
    chk({req, " R9 head word"}, d_out, e);
    ack_n = 1'b1;
    cyc(4);
    chk({req, " R9 drive off"}, d_oe, 1'b0);
  endtask

  task automatic dma_write(input logic [DW-1:0] d);
    wait_req("R10");
    d_in = d;
    ack_n = 1'b0;
    cyc(4);
    ack_n = 1'b1;
    cyc(3);
    exp_q.push_back(d);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 out_ready = v;
    @(negedge clk);
  endtask

  task automatic snap_rel(output int v);
    @(posedge clk);
    #1 v = rel_cnt;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!prev_req && req_n === 1'b1) rel_cnt++;
    prev_req = req_n;
  end

  // Scoreboard monitor for the output stream (R10, R12)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 out stream: actual %0h expected none", out_data);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (out_data !== e) begin
          errors++;
          $display("FAIL R10 out stream: actual %0h expected %0h", out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic oe;
    int r0, r1;
    rst_n = 1'b0; cs_n = 1'b1; rw = 1'b0; sel = 1'b0; uds_n = 1'b1; lds_n = 1'b1;
    ack_n = 1'b1; d_in = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    chk("R1 request idle", req_n, 1'b1);
    chk("R1 bus undriven", d_oe, 1'b0);
    chk("R1 in_ready", in_ready, 1'b0);
    chk("R1 out_valid", out_valid, 1'b0);
    reg_read_chk("R1 mode", 1'b0, 16'h0000);
    reg_read_chk("R1 control", 1'b1, 16'h0000);

    // R3 map, unused bits zero, byte lanes
    reg_write(1'b1, 16'h7FF5, 2'b11);
    reg_read_chk("R3 unused bits zero", 1'b1, 16'h0005);
    reg_write(1'b1, 16'hFF0A, 2'b01);
    reg_read_chk("R3 low lane only", 1'b1, 16'h000A);
    reg_write(1'b1, 16'h8000, 2'b10);
    reg_read_chk("R3 high lane only", 1'b1, 16'h800A);
    chk("R7 level above depth", req_n, 1'b1);
    reg_write(1'b1, 16'h0003, 2'b01);
    cyc(3);
    chk("R7 write direction free space", req_n, 1'b0);
    reg_write(1'b1, 16'h0000, 2'b10);
    cyc(2);
    chk("R6 disabled request", req_n, 1'b1);
    reg_read_chk("R3 enable cleared", 1'b1, 16'h0003);

    // R2 deselected: no drive, no write
    host_cycle(1'b1, 1'b0, 1'b1, 16'h0001, 2'b11, rd, oe);
    chk("R2 no drive", oe, 1'b0);
    host_cycle(1'b1, 1'b0, 1'b0, 16'h0001, 2'b11, rd, oe);
    reg_read_chk("R2 write ignored", 1'b0, 16'h0000);

    // R5 and R11: acknowledge low blocks register access
    @(negedge clk); ack_n = 1'b0;
    host_cycle(1'b0, 1'b0, 1'b1, 16'h0000, 2'b11, rd, oe);
    chk("R5 read blocked", oe, 1'b0);
    reg_write(1'b0, 16'h0001, 2'b11);
    @(negedge clk); ack_n = 1'b1;
    cyc(3);
    reg_read_chk("R5 write blocked", 1'b0, 16'h0000);

    // switch to read direction
    reg_write(1'b0, 16'h0001, 2'b01);
    reg_read_chk("R3 direction bit", 1'b0, 16'h0001);
    chk("R12 out_valid low in read dir", out_valid, 1'b0);

    // R7 read direction threshold
    push_item(16'hA001); push_item(16'hA002); push_item(16'hA003);
    reg_write(1'b1, 16'h8004, 2'b11);
    cyc(3);
    chk("R7 below level", req_n, 1'b1);
    push_item(16'hA004);
    cyc(3);
    chk("R7 level met", req_n, 1'b0);
    for (int i = 0; i < 4; i++) dma_read("R9 burst4");
    cyc(3);
    chk("R8 released after burst", req_n, 1'b1);

    // R8 two bursts of level 2
    reg_write(1'b1, 16'h0002, 2'b11);
    for (int i = 0; i < 4; i++) push_item(16'hB000 + 16'(i));
    snap_rel(r0);
    reg_write(1'b1, 16'h8002, 2'b11);
    for (int i = 0; i < 4; i++) dma_read("R8 burst2");
    cyc(4);
    snap_rel(r1);
    chk("R8 release count", r1 - r0, 2);

    // R11 acknowledge without request
    push_item(16'hC001);
    cyc(3);
    chk("R11 request idle", req_n, 1'b1);
    ack_n = 1'b0;
    cyc(4);
    chk("R11 no drive", d_oe, 1'b0);
    ack_n = 1'b1;
    cyc(4);
    push_item(16'hC002);
    dma_read("R11 word kept");
    dma_read("R11 word kept");

    // write direction
    reg_write(1'b1, 16'h0008, 2'b11);
    reg_write(1'b0, 16'h0000, 2'b01);
    chk("R12 in_ready low in write dir", in_ready, 1'b0);
    set_ready(1'b0);
    reg_write(1'b1, 16'h8008, 2'b11);
    for (int i = 0; i < 8; i++) dma_write(16'hD100 + 16'(i * 3));
    cyc(3);
    chk("R8 released when full", req_n, 1'b1);
    chk("R12 out_valid", out_valid, 1'b1);
    set_ready(1'b1);
    cyc(20);
    chk("R10 all words delivered", exp_q.size(), 0);
    chk("R7 free space regained", req_n, 1'b0);
    reg_write(1'b1, 16'h0000, 2'b11);
    cyc(2);
    chk("R6 disable drops request", req_n, 1'b1);
    reg_write(1'b1, 16'h8000, 2'b11);
    cyc(3);
    chk("R7 level zero acts as one", req_n, 1'b0);
    dma_write(16'hE55E);
    cyc(10);
    chk("R10 single word delivered", exp_q.size(), 0);
    reg_write(1'b1, 16'h0009, 2'b11);
    reg_write(1'b1, 16'h8009, 2'b11);
    cyc(3);
    chk("R7 level above depth never requests", req_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule